// File: doc/BRIEF.md
# Stream Configuration Cache

This block keeps decoded translation settings for recently used streams, so that the stream-table and context-descriptor structures in memory are not fetched and parsed again on every translation. A requester presents a 16-bit stream identifier on the lookup port. On a hit the cached record comes back at once. On a miss the block asks an external decoder for the configuration. It installs the answer only when the decode succeeds, and then it returns the answer.

A command port takes configuration-invalidation commands: one stream, a power-of-two range of streams, or the context descriptors of one stream. It also takes prefetch commands, which leave the cache alone. Lookups and commands are handled one at a time. A translation can therefore never observe an entry that is only partly invalidated.

Top module: `strm_cfg_cache`

## Requirements
- R1: A lookup accepted on a clock edge whose 16-bit stream ID (bus number in bits 15:8, device/function in bits 7:0) equals a valid entry's ID returns `lk_resp_valid` with `lk_hit`=1 and that entry's record one cycle after acceptance.
- R2: On a miss, `fill_req_valid` rises one cycle after acceptance with `fill_req_sid` equal to the looked-up ID. It stays high until `fill_rsp_valid`. The response (`lk_hit`=0) follows one cycle after the fill answer, and a successful fill is installed so that the next lookup of that ID hits.
- R3: A fill answer with `fill_rsp_err`=1 installs nothing and returns `lk_err`=1 with `lk_perm`=0. A repeated lookup of that ID misses again.
- R4: A record whose abort flag is set answers, whether it is filled or hit, with `lk_abort`=1 and `lk_perm`=0. A record that has neither error nor abort answers with `lk_perm`=1 and its configuration word.
- R5: Command op 1 (single stream) removes the entry whose ID equals `cmd_sid`. An ID that is not cached is ignored and every other entry stays.
- R6: Command op 2 removes every entry whose ID lies from `cmd_sid` to `cmd_sid + 2^(cmd_range+1) - 1` inclusive. With start 0 and `cmd_range`=31 it empties the whole cache.
- R7: Command ops 3 (one descriptor) and 4 (all descriptors of a stream) drop the whole entry of `cmd_sid`.
- R8: An op 1 to 4 command with `cmd_secure`=1 completes with `cmd_status`=1 (illegal) and changes no entry.
- R9: Op 0 (prefetch) and ops 5 to 7 complete with `cmd_status`=0 and change no entry.
- R10: Commands and lookups are serialized. `cmd_done` pulses one cycle after a command is accepted. Status 0 means ok. A pending command takes priority and holds `lk_ready` low. Both ready signals are low while a fill is outstanding.
- R11: There are 8 entries. A fill takes the lowest free slot; when no slot is free it replaces slots in round-robin order starting at slot 0.
- R12: Synchronous reset empties every entry and clears `lk_resp_valid`, `fill_req_valid` and `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_sid | input | 16 | Stream ID to look up |
| lk_resp_valid | output | 1 | Lookup response strobe |
| lk_hit | output | 1 | Served from the cache |
| lk_err | output | 1 | Decode failed |
| lk_abort | output | 1 | Stream configured to abort |
| lk_perm | output | 1 | Translation may proceed |
| lk_cfg | output | CFG_W | Decoded configuration word |
| fill_req_valid | output | 1 | Decode request to the external decoder |
| fill_req_sid | output | 16 | Stream ID to decode |
| fill_rsp_valid | input | 1 | Decoder answer strobe |
| fill_rsp_err | input | 1 | Decoder reports an error |
| fill_rsp_abort | input | 1 | Decoded stream aborts |
| fill_rsp_cfg | input | CFG_W | Decoded configuration word |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command opcode |
| cmd_sid | input | 16 | Stream ID or range start |
| cmd_range | input | 5 | Range exponent for op 2 |
| cmd_secure | input | 1 | Secure-stream bit |
| cmd_done | output | 1 | Command completion pulse |
| cmd_status | output | 2 | 0 ok, 1 illegal |

## Verification
The block's results fall due at fixed offsets. A hit answer and a fill request appear one cycle after the lookup is accepted, a miss answer one cycle after the decoder's strobe, and `cmd_done` one cycle after command acceptance. The bench drives inputs on falling edges and reads each result on the falling edge that follows the rising edge where it was registered. Every check is therefore made half a cycle after the output settles and half a cycle before it could change. Ready signals are combinational, so they are read on the same falling edge as the stimulus that affects them.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
    localparam int SID_W   = 16;
    localparam int RANGE_W = 5;
    localparam int SHIFT_W = 6;
    localparam int OP_W    = 3;
    localparam int STAT_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PREFETCH     = 3'd0,
        OP_INV_STREAM   = 3'd1,
        OP_INV_RANGE    = 3'd2,
        OP_INV_DESC     = 3'd3,
        OP_INV_DESC_ALL = 3'd4
    } cmd_op_e;

    localparam logic [STAT_W-1:0] ST_OK      = 2'd0;
    localparam logic [STAT_W-1:0] ST_ILLEGAL = 2'd1;

    typedef enum logic {S_IDLE, S_FILL} ctrl_state_e;

    typedef struct packed {
        logic hit;
        logic err;
        logic abort;
        logic perm;
    } resp_flags_t;

    function automatic logic is_inval(input logic [OP_W-1:0] op);
        return (op == OP_INV_STREAM) || (op == OP_INV_RANGE) ||
               (op == OP_INV_DESC)   || (op == OP_INV_DESC_ALL);
    endfunction

    // true when s is in [lo, lo + 2^sh - 1]; sh = 0 gives an exact match
    function automatic logic in_window(input logic [SID_W-1:0] s,
                                       input logic [SID_W-1:0] lo,
                                       input logic [SHIFT_W-1:0] sh);
        logic [SID_W:0] d;
        d = {1'b0, s} - {1'b0, lo};
        return !d[SID_W] && ((d[SID_W-1:0] >> sh) == '0);
    endfunction
endpackage

// File: rtl/cfgc_store.sv
module cfgc_store
    import cfgc_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CFG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SID_W-1:0]     look_sid,
    output logic                 hit,
    output logic                 hit_abort,
    output logic [CFG_W-1:0]     hit_cfg,
    input  logic                 fill_en,
    input  logic [SID_W-1:0]     fill_sid,
    input  logic                 fill_abort,
    input  logic [CFG_W-1:0]     fill_cfg,
    input  logic                 inv_en,
    input  logic [SID_W-1:0]     inv_lo,
    input  logic [SHIFT_W-1:0]   inv_shift
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    logic [N_ENT-1:0]  vld;
    logic [SID_W-1:0]  tag   [N_ENT];
    logic              abt   [N_ENT];
    logic [CFG_W-1:0]  data  [N_ENT];
    logic [N_ENT-1:0]  match;
    logic [N_ENT-1:0]  kill;
    logic [IDX_W-1:0]  rr_ptr;
    logic [IDX_W-1:0]  free_idx;
    logic              any_free;
    logic [IDX_W-1:0]  victim;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        assign match[i] = vld[i] && (tag[i] == look_sid);
        assign kill[i]  = vld[i] && in_window(tag[i], inv_lo, inv_shift);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i] <= 1'b0;
            end else if (inv_en && kill[i]) begin
                vld[i] <= 1'b0;
            end else if (fill_en && victim == IDX_W'(i)) begin
                vld[i]  <= 1'b1;
                tag[i]  <= fill_sid;
                abt[i]  <= fill_abort;
                data[i] <= fill_cfg;
            end
        end
    end

    always_comb begin
        hit       = 1'b0;
        hit_abort = 1'b0;
        hit_cfg   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) begin
                hit       = 1'b1;
                hit_abort = abt[i];
                hit_cfg   = data[i];
            end
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = any_free ? free_idx : rr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (fill_en && !any_free) begin
            rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
        end
    end

    p_match_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
    p_reset_empty_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld == '0));
    p_inval_clears_r6: assert property (@(posedge clk) disable iff (rst)
        inv_en |=> ((vld & $past(kill)) == '0));
    p_fill_lands_r2: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (vld != '0));
endmodule

// File: rtl/cfgc_ctrl.sv
module cfgc_ctrl
    import cfgc_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    output logic                 lk_ready,
    output logic                 lk_resp_valid,
    output resp_flags_t          lk_flags,
    output logic [CFG_W-1:0]     lk_cfg,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [RANGE_W-1:0]   cmd_range,
    input  logic                 cmd_secure,
    output logic                 cmd_done,
    output logic [STAT_W-1:0]    cmd_status,
    input  logic [SID_W-1:0]     lk_sid,
    output logic                 fill_req_valid,
    output logic [SID_W-1:0]     fill_req_sid,
    input  logic                 fill_rsp_valid,
    input  logic                 fill_rsp_err,
    input  logic                 fill_rsp_abort,
    input  logic [CFG_W-1:0]     fill_rsp_cfg,
    input  logic                 hit,
    input  logic                 hit_abort,
    input  logic [CFG_W-1:0]     hit_cfg,
    output logic                 fill_en,
    output logic                 inv_en,
    output logic [SHIFT_W-1:0]   inv_shift
);
    ctrl_state_e st;
    logic lk_acc, cmd_acc, inval_op;

    assign cmd_ready = (st == S_IDLE);
    assign lk_ready  = (st == S_IDLE) && !cmd_valid;
    assign lk_acc    = lk_valid && lk_ready;
    assign cmd_acc   = cmd_valid && cmd_ready;
    assign inval_op  = is_inval(cmd_op);
    assign inv_en    = cmd_acc && inval_op && !cmd_secure;
    assign inv_shift = (cmd_op == OP_INV_RANGE)
                     ? SHIFT_W'({1'b0, cmd_range}) + SHIFT_W'(1) : '0;
    assign fill_en   = (st == S_FILL) && fill_rsp_valid && !fill_rsp_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= S_IDLE;
            lk_resp_valid  <= 1'b0;
            lk_flags       <= '0;
            lk_cfg         <= '0;
            cmd_done       <= 1'b0;
            cmd_status     <= ST_OK;
            fill_req_valid <= 1'b0;
            fill_req_sid   <= '0;
        end else begin
            lk_resp_valid <= 1'b0;
            cmd_done      <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (cmd_acc) begin
                        cmd_done   <= 1'b1;
                        cmd_status <= (inval_op && cmd_secure) ? ST_ILLEGAL : ST_OK;
                    end else if (lk_acc) begin
                        if (hit) begin
                            lk_resp_valid <= 1'b1;
                            lk_flags      <= '{hit: 1'b1, err: 1'b0,
                                               abort: hit_abort, perm: !hit_abort};
                            lk_cfg        <= hit_cfg;
                        end else begin
                            st             <= S_FILL;
                            fill_req_valid <= 1'b1;
                            fill_req_sid   <= lk_sid;
                        end
                    end
                end
                S_FILL: begin
                    if (fill_rsp_valid) begin
                        st             <= S_IDLE;
                        fill_req_valid <= 1'b0;
                        lk_resp_valid  <= 1'b1;
                        lk_flags       <= '{hit: 1'b0, err: fill_rsp_err,
                                            abort: !fill_rsp_err && fill_rsp_abort,
                                            perm: !fill_rsp_err && !fill_rsp_abort};
                        lk_cfg         <= fill_rsp_err ? '0 : fill_rsp_cfg;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_serial_r10: assert property (@(posedge clk) disable iff (rst)
        !(lk_valid && lk_ready && cmd_valid && cmd_ready));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> cmd_done);
    p_secure_illegal_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_secure && cmd_op >= 3'd1 && cmd_op <= 3'd4)
        |=> (cmd_status == ST_ILLEGAL));
    p_err_noperm_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_resp_valid && lk_flags.err) |-> !lk_flags.perm);
    p_abort_noperm_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_resp_valid && lk_flags.abort) |-> !lk_flags.perm);
    p_fill_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_rsp_valid) |=> fill_req_valid);
    p_fill_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        fill_req_valid |-> (!cmd_ready && !lk_ready));
endmodule

// File: rtl/strm_cfg_cache.sv
module strm_cfg_cache
    import cfgc_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int CFG_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [15:0]       lk_sid,
    output logic              lk_resp_valid,
    output logic              lk_hit,
    output logic              lk_err,
    output logic              lk_abort,
    output logic              lk_perm,
    output logic [CFG_W-1:0]  lk_cfg,
    output logic              fill_req_valid,
    output logic [15:0]       fill_req_sid,
    input  logic              fill_rsp_valid,
    input  logic              fill_rsp_err,
    input  logic              fill_rsp_abort,
    input  logic [CFG_W-1:0]  fill_rsp_cfg,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [15:0]       cmd_sid,
    input  logic [4:0]        cmd_range,
    input  logic              cmd_secure,
    output logic              cmd_done,
    output logic [1:0]        cmd_status
);
    resp_flags_t        flags;
    logic               hit, hit_abort, fill_en, inv_en;
    logic [CFG_W-1:0]   hit_cfg;
    logic [SHIFT_W-1:0] inv_shift;

    assign lk_hit   = flags.hit;
    assign lk_err   = flags.err;
    assign lk_abort = flags.abort;
    assign lk_perm  = flags.perm;

    cfgc_store #(.N_ENT(N_ENT), .CFG_W(CFG_W)) u_store (
        .clk(clk), .rst(rst),
        .look_sid(lk_sid), .hit(hit), .hit_abort(hit_abort), .hit_cfg(hit_cfg),
        .fill_en(fill_en), .fill_sid(fill_req_sid), .fill_abort(fill_rsp_abort),
        .fill_cfg(fill_rsp_cfg),
        .inv_en(inv_en), .inv_lo(cmd_sid), .inv_shift(inv_shift)
    );

    cfgc_ctrl #(.CFG_W(CFG_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_resp_valid(lk_resp_valid),
        .lk_flags(flags), .lk_cfg(lk_cfg),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_range(cmd_range), .cmd_secure(cmd_secure),
        .cmd_done(cmd_done), .cmd_status(cmd_status),
        .lk_sid(lk_sid),
        .fill_req_valid(fill_req_valid), .fill_req_sid(fill_req_sid),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_err(fill_rsp_err),
        .fill_rsp_abort(fill_rsp_abort), .fill_rsp_cfg(fill_rsp_cfg),
        .hit(hit), .hit_abort(hit_abort), .hit_cfg(hit_cfg),
        .fill_en(fill_en), .inv_en(inv_en), .inv_shift(inv_shift)
    );
endmodule

// File: tb/sim_strm_cfg_cache.sv
`timescale 1ns/1ps
module sim_strm_cfg_cache;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0, lk_ready;
    logic [15:0] lk_sid = '0;
    logic lk_resp_valid, lk_hit, lk_err, lk_abort, lk_perm;
    logic [31:0] lk_cfg;
    logic fill_req_valid;
    logic [15:0] fill_req_sid;
    logic fill_rsp_valid = 1'b0, fill_rsp_err = 1'b0, fill_rsp_abort = 1'b0;
    logic [31:0] fill_rsp_cfg = '0;
    logic cmd_valid = 1'b0, cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [15:0] cmd_sid = '0;
    logic [4:0] cmd_range = '0;
    logic cmd_secure = 1'b0;
    logic cmd_done;
    logic [1:0] cmd_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    strm_cfg_cache u0 (.*);

    typedef struct packed {
        logic        is_cmd;
        logic [2:0]  op;
        logic [15:0] sid;
        logic [4:0]  rng;
        logic        sec;
        logic        hit;
        logic        err;
        logic        abt;
        logic [1:0]  st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 16'h0108, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},  // R2 miss+fill
        '{1'b0, 3'd0, 16'h0108, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd1},  // R1 hit
        '{1'b0, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
        '{1'b0, 3'd0, 16'hA300, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd4},  // R4 aborted fill
        '{1'b0, 3'd0, 16'hA300, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 4'd4},  // R4 aborted hit
        '{1'b0, 3'd0, 16'hE001, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3},  // R3 decode error
        '{1'b0, 3'd0, 16'hE001, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd3},  // R3 not installed
        '{1'b1, 3'd1, 16'h0108, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 single inval
        '{1'b0, 3'd0, 16'h0108, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5},
        '{1'b1, 3'd1, 16'h7777, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd5},  // R5 absent ID
        '{1'b0, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd5},
        '{1'b1, 3'd1, 16'h0210, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 4'd8},  // R8 secure
        '{1'b0, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd8},
        '{1'b1, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd9},  // R9 prefetch
        '{1'b0, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd9},
        '{1'b1, 3'd3, 16'h0210, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 one descriptor
        '{1'b0, 3'd0, 16'h0210, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},
        '{1'b1, 3'd4, 16'h0108, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},  // R7 all descriptors
        '{1'b0, 3'd0, 16'h0108, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd7},
        '{1'b0, 3'd0, 16'h0200, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
        '{1'b0, 3'd0, 16'h0203, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
        '{1'b0, 3'd0, 16'h0204, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
        '{1'b1, 3'd2, 16'h0200, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 0x200..0x203
        '{1'b0, 3'd0, 16'h0203, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd6},  // last in window
        '{1'b0, 3'd0, 16'h0204, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd6},  // first past window
        '{1'b0, 3'd0, 16'h0200, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd6},
        '{1'b0, 3'd0, 16'h0108, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd6},
        '{1'b1, 3'd2, 16'h0000, 5'd31, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd6}, // R6 all streams
        '{1'b0, 3'd0, 16'hA300, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd6},
        '{1'b0, 3'd0, 16'h0204, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 4'd6}
    };

    function automatic logic [31:0] stub_cfg(input logic [15:0] s);
        return {s, ~s};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // decoder stub answer: error for IDs 0xE***, abort for IDs 0xA***
    task automatic answer_fill(input logic [15:0] s);
        fill_rsp_valid = 1'b1;
        fill_rsp_err   = (s[15:12] == 4'hE);
        fill_rsp_abort = (s[15:12] == 4'hA);
        fill_rsp_cfg   = stub_cfg(s);
        @(negedge clk);
        fill_rsp_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [15:0] s, input string req,
                             output logic h, output logic e, output logic a,
                             output logic p, output logic [31:0] c);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_sid   = s;
        while (!lk_ready) @(negedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        if (!lk_resp_valid) begin
            check(fill_req_valid && fill_req_sid == s, req, "fill request id",
                  {16'h0, fill_req_sid}, {16'h0, s});
            @(negedge clk);
            check(fill_req_valid == 1'b1, req, "fill request held", 32'(fill_req_valid), 32'd1);
            answer_fill(s);
        end
        check(lk_resp_valid == 1'b1, req, "response strobe", 32'(lk_resp_valid), 32'd1);
        h = lk_hit; e = lk_err; a = lk_abort; p = lk_perm; c = lk_cfg;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [15:0] s,
                          input logic [4:0] r, input logic sec,
                          output logic d, output logic [1:0] stat);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sid = s; cmd_range = r; cmd_secure = sec;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_secure = 1'b0;
        d = cmd_done; stat = cmd_status;
    endtask

    task automatic lookup_expect(input logic [15:0] s, input logic eh, input logic ee,
                                 input logic ea, input string req);
        logic h, e, a, p;
        logic [31:0] c;
        logic ep;
        ep = !ee && !ea;
        do_lookup(s, req, h, e, a, p, c);
        check(h == eh, req, $sformatf("hit sid %0h", s), 32'(h), 32'(eh));
        check(e == ee, req, $sformatf("err sid %0h", s), 32'(e), 32'(ee));
        check(a == ea, req, $sformatf("abort sid %0h", s), 32'(a), 32'(ea));
        check(p == ep, req, $sformatf("perm sid %0h", s), 32'(p), 32'(ep));
        if (ep) check(c == stub_cfg(s), req, "cfg word", c, stub_cfg(s));
    endtask

    task automatic reset_block();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic d;
        logic [1:0] stat;
        repeat (3) @(negedge clk);
        // R12: outputs idle while in reset
        check(!lk_resp_valid && !fill_req_valid && !cmd_done, "R12", "idle outputs in reset",
              {29'h0, lk_resp_valid, fill_req_valid, cmd_done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(lk_ready && cmd_ready, "R10", "ready after reset",
              {30'h0, lk_ready, cmd_ready}, 32'd3);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i].req);
            if (VEC[i].is_cmd) begin
                do_cmd(VEC[i].op, VEC[i].sid, VEC[i].rng, VEC[i].sec, d, stat);
                check(d == 1'b1, tag, $sformatf("done vec %0d", i), 32'(d), 32'd1);
                check(stat == VEC[i].st, tag, $sformatf("status vec %0d", i),
                      32'(stat), 32'(VEC[i].st));
            end else begin
                lookup_expect(VEC[i].sid, VEC[i].hit, VEC[i].err, VEC[i].abt, tag);
            end
        end

        // R9: unused opcode is a no-op with ok status
        do_cmd(3'd6, 16'h0204, 5'd0, 1'b0, d, stat);
        check(d && stat == 2'd0, "R9", "unused op status", {30'h0, stat}, 32'd0);
        lookup_expect(16'h0204, 1'b1, 1'b0, 1'b0, "R9");

        // R12: reset empties the cache
        reset_block();
        lookup_expect(16'h0204, 1'b0, 1'b0, 1'b0, "R12");

        // R10: command and lookup presented together; command wins
        reset_block();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_sid = 16'h0; lk_valid = 1'b1; lk_sid = 16'h0330;
        #1;
        check(!lk_ready && cmd_ready, "R10", "lookup stalled by command",
              {30'h0, lk_ready, cmd_ready}, 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_done == 1'b1, "R10", "done one cycle after accept", 32'(cmd_done), 32'd1);
        #1;
        check(lk_ready == 1'b1, "R10", "lookup ready after command", 32'(lk_ready), 32'd1);
        @(negedge clk);
        lk_valid = 1'b0;
        check(fill_req_valid == 1'b1, "R10", "fill after stalled lookup", 32'(fill_req_valid), 32'd1);
        check(!cmd_ready && !lk_ready, "R10", "ready low during fill",
              {30'h0, cmd_ready, lk_ready}, 32'd0);
        answer_fill(16'h0330);
        check(lk_resp_valid && lk_perm, "R10", "stalled lookup answered",
              {30'h0, lk_resp_valid, lk_perm}, 32'd3);

        // R11: nine distinct fills into eight slots, round-robin victim slot 0
        reset_block();
        for (int k = 0; k < 9; k++) lookup_expect(16'h1000 + 16'(k), 1'b0, 1'b0, 1'b0, "R11");
        for (int k = 1; k < 9; k++) lookup_expect(16'h1000 + 16'(k), 1'b1, 1'b0, 1'b0, "R11");
        lookup_expect(16'h1000, 1'b0, 1'b0, 1'b0, "R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule